// File: doc/BRIEF.md
# NAND Page Single-Bit ECC Corrector

This block checks one or two 256-byte chunks of a NAND page after a read. For each chunk it takes the 24-bit parity code stored in the spare area and the code freshly computed over the data that was just read, forms the difference between them, and sorts the result into one of four outcomes. The outcomes are: clean data, a damaged parity field, a single flipped data bit, and damage beyond repair. When a single data bit is wrong, the block locates it and repairs it in the page buffer. The repair is a read of the affected byte, then a write of that byte with the one bit inverted.

Software or a page engine pulses `start_i` once the buffer and both code pairs are ready. The block latches the codes in that cycle, so its inputs are free afterwards. It walks the chunks in order, fixing as it goes. It then raises `done_o` for one cycle, with the verdict for the last chunk checked and, for a repair, the address and bit it changed.

Top module: `nand_ecc_fixer`

## Requirements
- R1: The code for chunk n is taken from bits 24n+23:24n of the code inputs, and byte k of a code sits at bits 8k+7:8k of that slice, with byte 0 least significant.
- R2: If the two codes of a chunk are equal, or either one is all zero, that chunk's verdict is clean (status 0) and the buffer is not written.
- R3: If the difference (calc XOR stored) has exactly one bit set, the verdict is parity-damaged (status 1) and the buffer is not written.
- R4: If the difference has exactly 11 bits set and its bits 10:0 XOR its bits 21:11 equal 0x7FF, the verdict is repaired (status 2). The byte offset within the chunk is difference bits 10:3 and the bit index is bits 2:0. These are reported on `fix_addr_o` (chunk*256 + offset) and `fix_bit_o`.
- R5: A repair is one cycle with `buf_rd_o` high and then one cycle with `buf_wr_o` high, both at the same address. The buffer returns read data in the cycle after the read strobe. The written byte is that read data with the selected bit inverted, and nothing else in the buffer changes.
- R6: Every other difference pattern gives the verdict uncorrectable (status 3) and no buffer write.
- R7: With `page512_i` high, chunk 1 is checked after chunk 0 and after any repair of chunk 0. Chunk 1 uses the upper code pair and buffer addresses 256 to 511. The final status is that of chunk 1.
- R8: With `page512_i` low, the upper code pair has no effect on status, location or buffer contents.
- R9: `done_o` is a one-cycle pulse. Take start sampled at edge 0 as the count origin, so the cycle after edge 0 is cycle 1. Each chunk that is not the last adds 3 cycles if repaired and 1 otherwise. The last chunk adds 3 cycles if repaired, in which case `done_o` coincides with the write, and 2 otherwise. Changes to `start_i`, `page512_i` and the codes while busy have no effect.
- R10: While reset is low, `done_o`, `buf_rd_o` and `buf_wr_o` are low, and the status reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a check; sampled only when idle |
| page512_i | input | 1 | 1: check two chunks, 0: check chunk 0 only |
| calc_code_i | input | 48 | Computed codes, chunk n at bits 24n+23:24n |
| stored_code_i | input | 48 | Stored codes, same layout |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 clean, 1 parity damaged, 2 repaired, 3 uncorrectable |
| fix_addr_o | output | 9 | Buffer address of the last repaired byte |
| fix_bit_o | output | 3 | Bit index of the last repair |
| buf_addr_o | output | 9 | Page buffer byte address |
| buf_rd_o | output | 1 | Buffer read strobe |
| buf_wr_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | 8 | Buffer write data |
| buf_rdata_i | input | 8 | Buffer read data, valid the cycle after the read strobe |

## Verification
The repair write of the last chunk and the completion pulse share one cycle, so the buffer must be updated by the same edge that ends the operation. Every one of the 2048 possible bit locations is driven as a repairable error in the final chunk. At the cycle where `done_o` rises, the bench checks that the write strobe is high, that the latency matches the count derived from R9, and, one edge later, that exactly one byte of its buffer model changed, by exactly the expected bit. Two-chunk pages mix all verdict pairs, so a repair in chunk 0 is followed by a fresh evaluation that must not disturb it.

// File: rtl/neccor_pkg.sv
// Shared constants and types for the NAND single-bit ECC corrector.
// Assumes a 24-bit code covering a 256-byte chunk (11 parity pairs + 2 spare bits).
package neccor_pkg;
    localparam int CODE_W      = 24;
    localparam int HALF_W      = 11;
    localparam int CHUNK_BYTES = 256;
    localparam int OFF_W       = 8;
    localparam int BIT_W       = 3;
    localparam int FIX_POP     = HALF_W;

    typedef enum logic [1:0] {
        VD_CLEAN   = 2'd0,
        VD_PARBAD  = 2'd1,
        VD_FIXED   = 2'd2,
        VD_UNCORR  = 2'd3
    } verdict_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_EVAL,
        SQ_READ,
        SQ_WRITE,
        SQ_DONE
    } seq_state_t;

    typedef struct packed {
        verdict_t          cls;
        logic [OFF_W-1:0]  byte_off;
        logic [BIT_W-1:0]  bit_idx;
    } chunk_result_t;
endpackage

// File: rtl/neccor_classify.sv
// Combinational syndrome former and classifier for one chunk.
// Assumes both codes are already assembled little-endian into CODE_W bits.
module neccor_classify
    import neccor_pkg::*;
(
    input  logic [CODE_W-1:0] calc_i,
    input  logic [CODE_W-1:0] stored_i,
    output chunk_result_t     result_o
);
    logic [CODE_W-1:0] diff;
    logic [HALF_W-1:0] loc_syn;
    logic [HALF_W-1:0] calc_fold;
    logic [HALF_W-1:0] stored_fold;
    logic [HALF_W-1:0] pair_syn;
    logic [4:0]        diff_pop;

    // Form the difference and the folded parity-pair syndromes.
    always_comb begin
        diff        = calc_i ^ stored_i;
        loc_syn     = calc_i[HALF_W-1:0] ^ stored_i[HALF_W-1:0];
        calc_fold   = calc_i[HALF_W-1:0] ^ calc_i[2*HALF_W-1:HALF_W];
        stored_fold = stored_i[HALF_W-1:0] ^ stored_i[2*HALF_W-1:HALF_W];
        pair_syn    = calc_fold ^ stored_fold;
    end

    // Count set bits of the difference.
    always_comb begin
        diff_pop = '0;
        for (int i = 0; i < CODE_W; i++) begin
            diff_pop = diff_pop + {4'd0, diff[i]};
        end
    end

    // Sort into the four verdicts; zero checks take priority.
    always_comb begin
        result_o.byte_off = loc_syn[HALF_W-1:BIT_W];
        result_o.bit_idx  = loc_syn[BIT_W-1:0];
        if (diff == '0 || calc_i == '0 || stored_i == '0) begin
            result_o.cls = VD_CLEAN;
        end else if (diff_pop == 5'd1) begin
            result_o.cls = VD_PARBAD;
        end else if (diff_pop == 5'(FIX_POP) && pair_syn == {HALF_W{1'b1}}) begin
            result_o.cls = VD_FIXED;
        end else begin
            result_o.cls = VD_UNCORR;
        end
    end
endmodule

// File: rtl/neccor_seq.sv
// Chunk sequencer: walks chunks, records verdicts and runs the
// read-then-write repair on the page buffer. Assumes the buffer returns
// read data one cycle after the read strobe.
module neccor_seq
    import neccor_pkg::*;
#(
    parameter  int CHUNKS = 2,
    localparam int IDX_W  = (CHUNKS > 1) ? $clog2(CHUNKS) : 1,
    localparam int ADDR_W = IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  last_idx_i,
    input  chunk_result_t     result_i,
    input  logic [7:0]        buf_rdata_i,
    output logic              busy_o,
    output logic [IDX_W-1:0]  chunk_idx_o,
    output logic              done_o,
    output logic [1:0]        status_o,
    output logic [ADDR_W-1:0] fix_addr_o,
    output logic [BIT_W-1:0]  fix_bit_o,
    output logic [ADDR_W-1:0] buf_addr_o,
    output logic              buf_rd_o,
    output logic              buf_wr_o,
    output logic [7:0]        buf_wdata_o
);
    seq_state_t        st_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_q;
    verdict_t          status_q;
    logic [ADDR_W-1:0] fix_addr_q;
    logic [BIT_W-1:0]  fix_bit_q;
    logic              on_last;

    assign on_last = (idx_q == last_q);

    // State, chunk index and recorded verdict/location.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= SQ_IDLE;
            idx_q      <= '0;
            last_q     <= '0;
            status_q   <= VD_CLEAN;
            fix_addr_q <= '0;
            fix_bit_q  <= '0;
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    if (start_i) begin
                        st_q   <= SQ_EVAL;
                        idx_q  <= '0;
                        last_q <= last_idx_i;
                    end
                end
                SQ_EVAL: begin
                    status_q <= result_i.cls;
                    if (result_i.cls == VD_FIXED) begin
                        fix_addr_q <= {idx_q, result_i.byte_off};
                        fix_bit_q  <= result_i.bit_idx;
                        st_q       <= SQ_READ;
                    end else if (on_last) begin
                        st_q <= SQ_DONE;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                SQ_READ: begin
                    st_q <= SQ_WRITE;
                end
                SQ_WRITE: begin
                    if (on_last) begin
                        st_q <= SQ_IDLE;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                        st_q  <= SQ_EVAL;
                    end
                end
                SQ_DONE: begin
                    st_q <= SQ_IDLE;
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    // Drive buffer strobes, repaired data and completion.
    always_comb begin
        busy_o      = (st_q != SQ_IDLE);
        chunk_idx_o = idx_q;
        buf_rd_o    = (st_q == SQ_READ);
        buf_wr_o    = (st_q == SQ_WRITE);
        buf_addr_o  = fix_addr_q;
        buf_wdata_o = buf_rdata_i ^ (8'd1 << fix_bit_q);
        done_o      = (st_q == SQ_DONE) || (st_q == SQ_WRITE && on_last);
        status_o    = status_q;
        fix_addr_o  = fix_addr_q;
        fix_bit_o   = fix_bit_q;
    end
endmodule

// File: rtl/nand_ecc_fixer.sv
// Top of the NAND single-bit ECC corrector. Latches all code pairs on an
// accepted start, classifies each chunk with its own classifier and lets
// the sequencer repair the page buffer. Assumes inputs need not be held.
module nand_ecc_fixer
    import neccor_pkg::*;
#(
    parameter  int CHUNKS = 2,
    localparam int IDX_W  = (CHUNKS > 1) ? $clog2(CHUNKS) : 1,
    localparam int ADDR_W = IDX_W + OFF_W,
    localparam int CODES_W = CHUNKS * CODE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               page512_i,
    input  logic [CODES_W-1:0] calc_code_i,
    input  logic [CODES_W-1:0] stored_code_i,
    output logic               done_o,
    output logic [1:0]         status_o,
    output logic [ADDR_W-1:0]  fix_addr_o,
    output logic [BIT_W-1:0]   fix_bit_o,
    output logic [ADDR_W-1:0]  buf_addr_o,
    output logic               buf_rd_o,
    output logic               buf_wr_o,
    output logic [7:0]         buf_wdata_o,
    input  logic [7:0]         buf_rdata_i
);
    logic             busy;
    logic             take;
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] last_idx;
    chunk_result_t    results [CHUNKS];
    chunk_result_t    cur_result;

    assign take     = start_i && !busy;
    assign last_idx = page512_i ? IDX_W'(CHUNKS - 1) : '0;

    for (genvar g = 0; g < CHUNKS; g++) begin : g_chunk
        logic [CODE_W-1:0] calc_q;
        logic [CODE_W-1:0] stored_q;

        // Latch this chunk's code pair when a start is accepted.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                calc_q   <= '0;
                stored_q <= '0;
            end else if (take) begin
                calc_q   <= calc_code_i[g*CODE_W +: CODE_W];
                stored_q <= stored_code_i[g*CODE_W +: CODE_W];
            end
        end

        neccor_classify u_cls (
            .calc_i   (calc_q),
            .stored_i (stored_q),
            .result_o (results[g])
        );
    end

    // Present the verdict of the chunk under evaluation.
    always_comb begin
        cur_result = results[cur_idx];
    end

    neccor_seq #(.CHUNKS(CHUNKS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .last_idx_i  (last_idx),
        .result_i    (cur_result),
        .buf_rdata_i (buf_rdata_i),
        .busy_o      (busy),
        .chunk_idx_o (cur_idx),
        .done_o      (done_o),
        .status_o    (status_o),
        .fix_addr_o  (fix_addr_o),
        .fix_bit_o   (fix_bit_o),
        .buf_addr_o  (buf_addr_o),
        .buf_rd_o    (buf_rd_o),
        .buf_wr_o    (buf_wr_o),
        .buf_wdata_o (buf_wdata_o)
    );
endmodule

// File: rtl/neccor_checker.sv
// Protocol checker for the corrector's buffer port and completion pulse.
// Assumes it is bound to nand_ecc_fixer.
module neccor_checker #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done_o,
    input logic [1:0]        status_o,
    input logic              buf_rd_o,
    input logic              buf_wr_o,
    input logic [ADDR_W-1:0] buf_addr_o
);
    assert_rd_then_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_o |=> buf_wr_o);

    assert_wr_after_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_o |-> $past(buf_rd_o));

    assert_addr_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_o |-> buf_addr_o == $past(buf_addr_o));

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rd_o && buf_wr_o));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_fix_done_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o == 2'd2) |-> buf_wr_o);

    assert_nofix_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o != 2'd2) |-> !buf_wr_o);

    assert_quiet_reset_R10: assert property (@(posedge clk)
        !rst_n |=> (!done_o && !buf_rd_o && !buf_wr_o));
endmodule

bind nand_ecc_fixer neccor_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_o     (done_o),
    .status_o   (status_o),
    .buf_rd_o   (buf_rd_o),
    .buf_wr_o   (buf_wr_o),
    .buf_addr_o (buf_addr_o)
);

// File: tb/nand_ecc_fixer_bench.sv
module nand_ecc_fixer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PAGE = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        page512_i = 1'b0;
    logic [47:0] calc_code_i = '0;
    logic [47:0] stored_code_i = '0;
    logic        done_o;
    logic [1:0]  status_o;
    logic [8:0]  fix_addr_o;
    logic [2:0]  fix_bit_o;
    logic [8:0]  buf_addr_o;
    logic        buf_rd_o;
    logic        buf_wr_o;
    logic [7:0]  buf_wdata_o;
    logic [7:0]  buf_rdata_i;

    int total = 0;
    int bad = 0;
    int wr_cnt = 0;
    logic [7:0] mem [PAGE];
    logic [7:0] exp_mem [PAGE];

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_ecc_fixer u_nand_ecc_fixer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .page512_i(page512_i),
        .calc_code_i(calc_code_i), .stored_code_i(stored_code_i),
        .done_o(done_o), .status_o(status_o), .fix_addr_o(fix_addr_o),
        .fix_bit_o(fix_bit_o), .buf_addr_o(buf_addr_o), .buf_rd_o(buf_rd_o),
        .buf_wr_o(buf_wr_o), .buf_wdata_o(buf_wdata_o), .buf_rdata_i(buf_rdata_i)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    // Page buffer model: registered read, write on strobe, filled in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE; i++) mem[i] <= pat(i);
            buf_rdata_i <= '0;
            wr_cnt <= 0;
        end else begin
            if (buf_rd_o) buf_rdata_i <= mem[buf_addr_o];
            if (buf_wr_o) begin
                mem[buf_addr_o] <= buf_wdata_o;
                wr_cnt <= wr_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected verdict from the requirement text (R2, R3, R4, R6).
    function automatic int classify(input logic [23:0] c, input logic [23:0] s,
                                    output int off, output int bitn);
        logic [23:0] e;
        int pop;
        e = c ^ s;
        off = int'(e[10:3]);
        bitn = int'(e[2:0]);
        pop = 0;
        for (int i = 0; i < 24; i++) if (e[i]) pop++;
        if (e == 0 || c == 0 || s == 0) return 0;
        if (pop == 1) return 1;
        if (pop == 11 && e[21:11] == ~e[10:0]) return 2;
        return 3;
    endfunction

    task automatic run_case(input bit p512, input logic [47:0] calc,
                            input logic [47:0] stored, input string tag);
        int n, lat, ewr, st, off, bitn, last_st, last_addr, last_bit, k, w0, mis;
        n = p512 ? 2 : 1;
        lat = 0; ewr = 0; last_st = 0; last_addr = 0; last_bit = 0;
        for (int ch = 0; ch < n; ch++) begin
            st = classify(calc[ch*24 +: 24], stored[ch*24 +: 24], off, bitn);
            last_st = st;
            if (st == 2) begin
                exp_mem[ch*256 + off] = exp_mem[ch*256 + off] ^ 8'(1 << bitn);
                ewr++;
                lat += 3;
                last_addr = ch*256 + off;
                last_bit = bitn;
            end else begin
                lat += (ch == n - 1) ? 2 : 1;
            end
        end
        w0 = wr_cnt;
        @(negedge clk);
        page512_i = p512; calc_code_i = calc; stored_code_i = stored; start_i = 1'b1;
        k = 0;
        // Hold start and scramble inputs while busy (R9: ignored).
        forever begin
            @(negedge clk);
            k++;
            calc_code_i = {$urandom, $urandom};
            stored_code_i = {$urandom, $urandom};
            page512_i = ~p512;
            if (done_o || k > 40) break;
        end
        chk(k == lat, "R9", {tag, " latency"}, k, lat);
        chk(status_o == 2'(last_st), (last_st == 2) ? "R4" : (last_st == 1) ? "R3" :
            (last_st == 3) ? "R6" : "R2", {tag, " status"}, status_o, last_st);
        if (last_st == 2) begin
            chk(fix_addr_o == 9'(last_addr), "R4", {tag, " addr"}, fix_addr_o, last_addr);
            chk(fix_bit_o == 3'(last_bit), "R4", {tag, " bit"}, fix_bit_o, last_bit);
            chk(buf_wr_o == 1'b1, "R9", {tag, " write with done"}, buf_wr_o, 1);
        end
        start_i = 1'b0;
        @(negedge clk);
        chk(done_o == 1'b0, "R9", {tag, " done pulse"}, done_o, 0);
        chk(wr_cnt - w0 == ewr, "R5", {tag, " write count"}, wr_cnt - w0, ewr);
        mis = 0;
        for (int a = 0; a < PAGE; a++) if (mem[a] !== exp_mem[a]) mis++;
        chk(mis == 0, p512 ? "R7" : "R5", {tag, " buffer contents"}, mis, 0);
    endtask

    function automatic logic [23:0] fix_err(input int loc);
        logic [10:0] l;
        l = 11'(loc);
        return {2'b00, ~l, l};
    endfunction

    initial begin
        for (int i = 0; i < PAGE; i++) exp_mem[i] = pat(i);
        repeat (3) @(negedge clk);
        chk(!done_o && !buf_rd_o && !buf_wr_o, "R10", "strobes in reset",
            {done_o, buf_rd_o, buf_wr_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status_o == 2'd0 && !done_o, "R10", "idle after reset", status_o, 0);

        // R1: byte order of the code; error at offset 0x24 bit 3.
        begin
            logic [23:0] s;
            s = {8'hC3, 8'h5A, 8'h91};
            run_case(1'b0, {24'h0, s ^ fix_err(11'h123)}, {24'h0, s}, "R1 byte order");
            chk(fix_addr_o == 9'h024 && fix_bit_o == 3'd3, "R1", "location",
                {fix_addr_o, fix_bit_o}, {9'h024, 3'd3});
        end

        // R2: clean cases.
        run_case(1'b0, {24'h0, 24'h5A5A5A}, {24'h0, 24'h5A5A5A}, "R2 equal");
        run_case(1'b0, {24'h0, 24'h000FFF}, {24'h0, 24'h000000}, "R2 stored zero");
        run_case(1'b0, {24'h0, 24'h000000}, {24'h0, 24'h7FF800}, "R2 calc zero");

        // R3: each single-bit difference.
        for (int b = 0; b < 24; b++)
            run_case(1'b0, {24'h0, 24'h800001 ^ (24'd1 << b)}, {24'h0, 24'h800001}, "R3 single");

        // R6: patterns that fail the repair test.
        run_case(1'b0, {24'h0, 24'h123456 ^ 24'h000003}, {24'h0, 24'h123456}, "R6 double");
        run_case(1'b0, {24'h0, 24'h123456 ^ 24'h4003FF}, {24'h0, 24'h123456}, "R6 pop11 spare");
        run_case(1'b0, {24'h0, 24'h123456 ^ 24'h0007FF ^ 24'h000800}, {24'h0, 24'h123456}, "R6 pop12");

        // R4/R5/R8: every location in a single chunk, upper pair as noise.
        for (int loc = 0; loc < 2048; loc++) begin
            logic [23:0] s;
            s = 24'h800000 | 24'($urandom);
            run_case(1'b0, {fix_err((loc * 5) & 2047), s ^ fix_err(loc)},
                     {24'h0F0F0F, s}, "R4 sweep");
        end

        // R7: every verdict pair across two chunks.
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                logic [23:0] d0, d1;
                d0 = (a == 0) ? 24'h0 : (a == 1) ? 24'h000400 : (a == 2) ? fix_err(11'h2B5) : 24'h000030;
                d1 = (b == 0) ? 24'h0 : (b == 1) ? 24'h200000 : (b == 2) ? fix_err(11'h4C6) : 24'hC00001;
                run_case(1'b1, {24'h3C3C3C ^ d1, 24'h818181 ^ d0},
                         {24'h3C3C3C, 24'h818181}, "R7 pair");
            end
        end

        // R8: correctable upper pair ignored in single-chunk mode.
        run_case(1'b0, {24'h6D6D6D ^ fix_err(11'h0AA), 24'h111111},
                 {24'h6D6D6D, 24'h111111}, "R8 upper ignored");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule